// File: doc/BRIEF.md
# USB Bus Activity Detector

This block watches the decoded line state of a full-speed USB bus and raises an active-high activity flag while packets are travelling on it. A bit-rate strobe marks the clock cycles on which the 2-bit line-state code holds a valid bit. The code is ignored in all other cycles.

The flag goes high when the start-of-packet synchronisation pattern appears on the line. It goes low again in two cases: the bus has been driven to single-ended zero long enough to count as a bus reset, or the line has rested in the idle J state for 32 bit times in a row. The block does not decode the contents of packets. It can drive an activity LED, a power-management wake source, or a multiplexed status pin.

Top module: `usb_activity_det`

## Requirements
- R1: While reset is asserted, and after reset until the first synchronisation pattern, `bus_active` is 0.
- R2: The line code is read as 2'b01 = J, 2'b10 = K and 2'b00 = SE0. The code 2'b11 is a symbol that is neither J nor SE0 and is never part of the synchronisation pattern.
- R3: The line code is sampled only in cycles where `bit_stb` is 1. `bus_active` changes only at the clock edge that ends a strobe cycle, and line values in other cycles have no effect.
- R4: When eight consecutive strobed symbols form K J K J K J K K, oldest first, `bus_active` is 1 after the clock edge of the final K.
- R5: When 32 consecutive strobed symbols are J, `bus_active` is 0 after the edge of the 32nd J. After 31 J symbols it is still 1.
- R6: A strobed K, SE0 or 2'b11 symbol restarts the J count, so two runs of 31 J separated by one such symbol leave the flag set.
- R7: When `RESET_BITS` consecutive strobed symbols are SE0, `bus_active` is 0 after the edge of the last of them. A run of `RESET_BITS`-1 SE0 symbols followed by J does not clear the flag.
- R8: A pattern in which any of the eight positions holds 2'b11 instead of the expected J or K does not set the flag.
- R9: Without a clearing condition the flag holds its value, including through ordinary K/J traffic and through a repeated synchronisation pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_stb | input | 1 | High for one cycle per USB bit time |
| line_st | input | 2 | Decoded line state: 01 J, 10 K, 00 SE0, 11 invalid |
| bus_active | output | 1 | Active-high bus-activity flag |

## Verification
The assertions assume that `line_st` is meaningful only in strobe cycles and that the set and clear causes never arrive in the same bit, because the pattern ends in K while both clear conditions need J or SE0. They also take the internal reset release as the start of observation, so the bench leaves `bit_stb` low for several cycles after deasserting `rst_n`. The stimulus mixes directed sequences at the exact thresholds with a long random stretch. That stretch has gaps between strobes, garbage codes during the gaps and occasional injected synchronisation bursts. It checks every cycle against a behavioural model.

// File: rtl/usbact_pkg.sv
package usbact_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_BAD = 2'b11
  } line_sym_e;

  localparam int SYNC_LEN = 8;

  // Symbol expected at pattern position idx (0 = oldest).
  function automatic line_sym_e sync_sym(input int idx);
    if (idx == SYNC_LEN - 1) return LS_K;
    return (idx % 2 == 0) ? LS_K : LS_J;
  endfunction

endpackage

// File: rtl/usbact_rst_sync.sv
module usbact_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/usbact_sync_match.sv
module usbact_sync_match
  import usbact_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  line_sym_e sym,
  output logic      hit
);
  localparam int HIST = SYNC_LEN - 1;

  line_sym_e hist_q [HIST];
  line_sym_e hist_d [HIST];
  logic [HIST-1:0] pos_ok;

  always_comb begin
    for (int k = 0; k < HIST; k++) hist_d[k] = hist_q[k];
    if (en) begin
      hist_d[0] = sym;
      for (int k = 1; k < HIST; k++) hist_d[k] = hist_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HIST; k++) hist_q[k] <= LS_SE0;
    end else begin
      for (int k = 0; k < HIST; k++) hist_q[k] <= hist_d[k];
    end
  end

  // hist_q[0] is the newest stored symbol, position SYNC_LEN-2 in the pattern.
  for (genvar g = 0; g < HIST; g++) begin : g_cmp
    assign pos_ok[g] = (hist_q[g] == sync_sym(SYNC_LEN - 2 - g));
  end

  assign hit = en && (sym == sync_sym(SYNC_LEN - 1)) && (&pos_ok);
endmodule

// File: rtl/usbact_run_cnt.sv
module usbact_run_cnt #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic match,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (!match)                 cnt_d = '0;
      else if (cnt_q != CW'(LIMIT)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = en && match && (cnt_q >= CW'(LIMIT - 1));
endmodule

// File: rtl/usb_activity_det.sv
module usb_activity_det
  import usbact_pkg::*;
#(
  parameter int IDLE_BITS  = 32,
  parameter int RESET_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic [1:0] line_st,
  output logic       bus_active
);
  line_sym_e sym;
  logic rst_q_n;
  logic sync_hit, idle_hit, reset_hit;
  logic act_q, act_d;

  assign sym = line_sym_e'(line_st);

  usbact_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  usbact_sync_match u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (bit_stb),
    .sym   (sym),
    .hit   (sync_hit)
  );

  usbact_run_cnt #(.LIMIT(IDLE_BITS)) u_idle (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (bit_stb),
    .match (sym == LS_J),
    .hit   (idle_hit)
  );

  usbact_run_cnt #(.LIMIT(RESET_BITS)) u_se0 (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (bit_stb),
    .match (sym == LS_SE0),
    .hit   (reset_hit)
  );

  always_comb begin
    act_d = act_q;
    if (idle_hit || reset_hit) act_d = 1'b0;
    else if (sync_hit)         act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) act_q <= 1'b0;
    else          act_q <= act_d;
  end

  assign bus_active = act_q;
endmodule

// File: rtl/usbact_chk.sv
module usbact_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic [1:0] line_st,
  input logic       bus_active,
  input logic       sync_hit,
  input logic       idle_hit,
  input logic       reset_hit
);
  // R3: no change without a strobe
  a_r3_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(bus_active));

  // R4: rising flag follows a strobed K
  a_r4_rise_on_k: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_active) |-> ($past(bit_stb) && $past(line_st) == 2'b10));

  // R4: recognised pattern sets the flag
  a_r4_sync_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> bus_active);

  // R5: idle run clears the flag
  a_r5_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> !bus_active);

  // R7: bus reset clears the flag
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> !bus_active);

  // R9: flag falls only after a strobed J or SE0
  a_r9_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_active) |-> ($past(bit_stb) &&
      ($past(line_st) == 2'b01 || $past(line_st) == 2'b00)));

  // R2: the three causes exclude each other
  a_r2_causes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_hit, idle_hit, reset_hit}));
endmodule

bind usb_activity_det usbact_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .bit_stb    (bit_stb),
  .line_st    (line_st),
  .bus_active (bus_active),
  .sync_hit   (sync_hit),
  .idle_hit   (idle_hit),
  .reset_hit  (reset_hit)
);

// File: tb/test_usb_activity_det.sv
`timescale 1ns/1ps
module test_usb_activity_det;
  localparam int RB = 10;
  localparam int IB = 32;
  localparam logic [1:0] J = 2'b01, K = 2'b10, Z = 2'b00, X = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_stb;
  logic [1:0] line_st;
  logic bus_active;

  int checks = 0;
  int errors = 0;

  logic [1:0] hist[$];
  int jrun = 0, zrun = 0;
  bit mflag = 0;

  always #5 clk = ~clk;

  usb_activity_det #(.IDLE_BITS(IB), .RESET_BITS(RB)) i_usb_activity_det (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .line_st(line_st), .bus_active(bus_active)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bus_active=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_sync();
    logic [1:0] pat[8] = '{K, J, K, J, K, J, K, K};
    if (hist.size() != 8) return 0;
    for (int i = 0; i < 8; i++) if (hist[i] != pat[i]) return 0;
    return 1;
  endfunction

  function automatic void model(input logic [1:0] s);
    hist.push_back(s);
    if (hist.size() > 8) void'(hist.pop_front());
    jrun = (s == J) ? ((jrun < IB) ? jrun + 1 : IB) : 0;
    zrun = (s == Z) ? ((zrun < RB) ? zrun + 1 : RB) : 0;
    if (jrun >= IB || zrun >= RB) mflag = 0;
    else if (is_sync()) mflag = 1;
  endfunction

  task automatic step(input logic [1:0] s, input bit stb, input string tag);
    @(negedge clk);
    chk(bus_active, mflag, tag);
    bit_stb = stb;
    line_st = s;
    if (stb) model(s);
  endtask

  task automatic want(input logic exp, input string tag);
    step(J, 0, tag);
    chk(bus_active, exp, tag);
  endtask

  task automatic syms(input logic [1:0] s, input int n, input string tag);
    for (int i = 0; i < n; i++) step(s, 1, tag);
  endtask

  task automatic sync_burst(input string tag);
    logic [1:0] pat[8] = '{K, J, K, J, K, J, K, K};
    for (int i = 0; i < 8; i++) step(pat[i], 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_stb = 1'b0; line_st = J;
    repeat (3) @(negedge clk);
    chk(bus_active, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_active, 1'b0, "R1 after reset");

    syms(J, 40, "R1 idle");
    want(1'b0, "R1 idle stays low");

    sync_burst("R4");
    want(1'b1, "R4 sync sets");
    syms(K, 3, "R9"); syms(J, 2, "R9"); step(K, 1, "R9");
    want(1'b1, "R9 traffic holds");

    // R3: pattern with gaps carrying SE0 and invalid codes
    syms(J, IB, "R5");
    want(1'b0, "R5 cleared before R3 test");
    begin
      logic [1:0] pat[8] = '{K, J, K, J, K, J, K, K};
      for (int i = 0; i < 8; i++) begin
        step(Z, 0, "R3 gap"); step(X, 0, "R3 gap");
        step(pat[i], 1, "R3");
      end
    end
    want(1'b1, "R3 gaps ignored");

    syms(J, IB - 1, "R5");
    want(1'b1, "R5 31 J holds");
    step(J, 1, "R5");
    want(1'b0, "R5 32nd J clears");

    sync_burst("R6");
    syms(J, IB - 1, "R6"); step(K, 1, "R6");
    syms(J, IB - 1, "R6"); step(X, 1, "R6");
    syms(J, IB - 1, "R6"); step(Z, 1, "R6");
    syms(J, IB - 1, "R6");
    want(1'b1, "R6 non-J restarts count");
    step(J, 1, "R6");
    want(1'b0, "R6 final J clears");

    sync_burst("R7");
    syms(Z, RB - 1, "R7"); step(J, 1, "R7");
    want(1'b1, "R7 short SE0 holds");
    syms(Z, RB, "R7");
    want(1'b0, "R7 bus reset clears");

    step(K, 1, "R8"); step(J, 1, "R8"); step(K, 1, "R8"); step(X, 1, "R8");
    step(K, 1, "R8"); step(J, 1, "R8"); step(K, 1, "R8"); step(K, 1, "R8");
    want(1'b0, "R8 invalid code blocks");
    step(K, 1, "R8"); step(J, 1, "R8"); step(K, 1, "R8"); step(J, 1, "R8");
    step(K, 1, "R8"); step(J, 1, "R8"); step(K, 1, "R8"); step(X, 1, "R8");
    want(1'b0, "R8 invalid last symbol");
    step(K, 1, "R2"); step(J, 1, "R2"); step(K, 1, "R2"); step(J, 1, "R2");
    step(K, 1, "R2"); step(J, 1, "R2"); step(K, 1, "R2"); step(K, 1, "R2");
    want(1'b1, "R2 encodings");

    sync_burst("R9"); sync_burst("R9");
    want(1'b1, "R9 repeated sync holds");

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) sync_burst("R9 random");
      else if (r < 4) syms(J, IB, "R5 random");
      else begin
        logic [1:0] s = 2'($urandom_range(0, 3));
        step(s, ($urandom_range(0, 3) != 0), "R3 random");
      end
    end
    step(J, 0, "R3 final");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule